// File: doc/BRIEF.md
# Pin Interrupt Aggregator

This block collects interrupt requests from a parameterised set of external pin inputs (64 by default) and turns them into per-channel status bits and one combined interrupt line to the processor. Every pin is first brought into the clock domain by a two-stage synchroniser. Each channel can then trigger on one selected edge or on an active level.

Software configures each channel through a memory-mapped port that takes one 32-bit word per cycle. The mask, trigger-type and polarity fields each have three addresses: one to read the field, one where written ones set bits, and one where written ones clear bits. Software can therefore change a single channel without a read-modify-write sequence. A write-one acknowledge address clears latched status. A directly written routing word decides whether a channel may raise status at all.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, every channel is masked, edge-triggered and active-low (falling edge). All status bits, all routing bits and `irq_o` are 0.
- R2: Channel n occupies bit n%32 of the word at region base + (n/32)*4. The region bases are:
  - status 0x000 (read)
  - acknowledge 0x040
  - mask 0x080 (read), mask-set 0x0C0, mask-clear 0x100
  - trigger type 0x140 (read), type-set 0x180, type-clear 0x1C0
  - polarity 0x300 (read), polarity-set 0x340, polarity-clear 0x380
  - routing 0x400 (read/write)

  Reads of the set, clear and acknowledge aliases, of unmapped regions, and of words beyond the channel count return 0.
- R3: Writing a 1 to a mask-set bit masks that channel, and a 1 to a mask-clear bit unmasks it. Bits written as 0 leave the mask unchanged.
- R4: The trigger-type field is changed through its set and clear aliases with the same write-one semantics. A 1 selects level triggering and a 0 selects edge triggering.
- R5: The polarity field is changed through its set and clear aliases with the same write-one semantics. A 1 selects rising edge or active-high, and a 0 selects falling edge or active-low.
- R6: An edge channel latches status on its selected edge only. Status appears three clock edges after the pin changes (two synchroniser stages, then the status register). It holds until acknowledged, even after the pin returns.
- R7: Writing 1 to an acknowledge bit clears that channel's latched status. Bits written as 0 have no effect. If a new edge is detected in the same cycle as the acknowledge, the edge wins and status stays set.
- R8: A level channel's status follows the synchronised active level. An acknowledge clears it for one cycle, and it is re-asserted on the next cycle while the level persists. Status falls three edges after the pin goes inactive.
- R9: The routing word is written directly and read back. A channel whose routing bit is 0 never sets its status bit.
- R10: `irq_o` is the OR over all channels of status AND NOT mask. It follows the status and mask registers without an extra register stage.
- R11: Read data is combinational from the address in the same cycle, and a write takes effect at the clock edge where `reg_we` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | NUM_CH | Asynchronous external interrupt pins |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_o | output | 1 | Combined interrupt to the processor |

## Verification
The hardest case to reach from the ports is an acknowledge arriving in the same clock cycle as a fresh edge on the same channel. That case decides whether an event is lost. The bench drives the pin low and then waits exactly two clock edges. It then issues the acknowledge write so that its strobe meets the third edge, where the synchronised edge reaches the status register. It then checks that status survives.

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter int NUM_CH = 64,
  parameter int AW     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] pin_i,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_o
);
  localparam int WORDS = (NUM_CH + 31) / 32;
  localparam int NW    = WORDS * 32;
  localparam logic [AW-1:0] OFF_STAT = AW'(12'h000);
  localparam logic [AW-1:0] OFF_ACK  = AW'(12'h040);
  localparam logic [AW-1:0] OFF_MASK = AW'(12'h080);
  localparam logic [AW-1:0] OFF_MSET = AW'(12'h0C0);
  localparam logic [AW-1:0] OFF_MCLR = AW'(12'h100);
  localparam logic [AW-1:0] OFF_SENS = AW'(12'h140);
  localparam logic [AW-1:0] OFF_SSET = AW'(12'h180);
  localparam logic [AW-1:0] OFF_SCLR = AW'(12'h1C0);
  localparam logic [AW-1:0] OFF_POL  = AW'(12'h300);
  localparam logic [AW-1:0] OFF_PSET = AW'(12'h340);
  localparam logic [AW-1:0] OFF_PCLR = AW'(12'h380);
  localparam logic [AW-1:0] OFF_DOM  = AW'(12'h400);

  logic [NUM_CH-1:0] s1, s2, s3;
  logic [NUM_CH-1:0] mask_q, sens_q, pol_q, dom_q, status_q;
  logic [NUM_CH-1:0] wbits, wsel, ack_v, lvl_hit, edg_hit, status_n;
  logic [AW-1:0]     base;
  logic [3:0]        widx;
  logic              wok;
  logic              wr_ack, wr_mset, wr_mclr, wr_sset, wr_sclr, wr_pset, wr_pclr, wr_dom;
  logic [NW-1:0]     rd_src;

  assign base = {reg_addr[AW-1:6], 6'b0};
  assign widx = reg_addr[5:2];
  assign wok  = 32'(widx) < WORDS;

  assign wr_ack  = reg_we && wok && base == OFF_ACK;
  assign wr_mset = reg_we && wok && base == OFF_MSET;
  assign wr_mclr = reg_we && wok && base == OFF_MCLR;
  assign wr_sset = reg_we && wok && base == OFF_SSET;
  assign wr_sclr = reg_we && wok && base == OFF_SCLR;
  assign wr_pset = reg_we && wok && base == OFF_PSET;
  assign wr_pclr = reg_we && wok && base == OFF_PCLR;
  assign wr_dom  = reg_we && wok && base == OFF_DOM;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_wbit
    assign wsel[i]  = 32'(widx) == i / 32;
    assign wbits[i] = wsel[i] && reg_wdata[i % 32];
  end

  assign ack_v   = wr_ack ? wbits : '0;
  assign lvl_hit = dom_q & ~(s2 ^ pol_q);
  assign edg_hit = dom_q & ((pol_q & s2 & ~s3) | (~pol_q & ~s2 & s3));
  assign status_n = (sens_q & lvl_hit & ~ack_v) |
                    (~sens_q & ((status_q & ~ack_v) | edg_hit));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
      mask_q <= '1; sens_q <= '0; pol_q <= '0; dom_q <= '0; status_q <= '0;
    end else begin
      s1 <= pin_i;
      s2 <= s1;
      s3 <= s2;
      status_q <= status_n;
      if (wr_mset) mask_q <= mask_q | wbits;
      if (wr_mclr) mask_q <= mask_q & ~wbits;
      if (wr_sset) sens_q <= sens_q | wbits;
      if (wr_sclr) sens_q <= sens_q & ~wbits;
      if (wr_pset) pol_q  <= pol_q | wbits;
      if (wr_pclr) pol_q  <= pol_q & ~wbits;
      if (wr_dom)  dom_q  <= (dom_q & ~wsel) | wbits;
    end
  end

  always_comb begin
    case (base)
      OFF_STAT: rd_src = NW'(status_q);
      OFF_MASK: rd_src = NW'(mask_q);
      OFF_SENS: rd_src = NW'(sens_q);
      OFF_POL:  rd_src = NW'(pol_q);
      OFF_DOM:  rd_src = NW'(dom_q);
      default:  rd_src = '0;
    endcase
  end

  assign reg_rdata = wok ? rd_src[32*int'(widx) +: 32] : 32'h0;
  assign irq_o     = |(status_q & ~mask_q);

  // R3
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mset |=> ((mask_q & $past(wbits)) == $past(wbits)));
  // R3
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mclr |=> ((mask_q & $past(wbits)) == '0));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R9
    dom_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_q[i]) |-> $past(dom_q[i]));
    // R6
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sens_q[i] && status_q[i] && !ack_v[i] |=> status_q[i]);
    // R7
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sens_q[i] && ack_v[i] && !edg_hit[i] |=> !status_q[i]);
    // R8
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sens_q[i] && lvl_hit[i] && !ack_v[i] |=> status_q[i]);
  end
endmodule

// File: tb/ext_irq_ctrl_bench.sv
`timescale 1ns/1ps
module ext_irq_ctrl_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] pin_i = '1;
  logic        reg_we = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;
  int total = 0, fails = 0;
  bit done = 0;

  ext_irq_ctrl u_ext_irq_ctrl (.clk(clk), .rst_n(rst_n), .pin_i(pin_i), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o));

  always #2 clk = ~clk;

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(posedge clk); #1;
    reg_we = 0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
    reg_addr = a; #0.5;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic t_reset;
    chk_rd("R1 status w0", 12'h000, 32'h0);
    chk_rd("R1 mask w0", 12'h080, 32'hFFFF_FFFF);
    chk_rd("R1 mask w1", 12'h084, 32'hFFFF_FFFF);
    chk_rd("R1 sens", 12'h140, 32'h0);
    chk_rd("R1 pol", 12'h304, 32'h0);
    chk_rd("R1 dom", 12'h400, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    chk_rd("R2 alias reads zero", 12'h0C0, 32'h0);
    chk_rd("R2 word beyond range", 12'h088, 32'h0);
  endtask

  task automatic t_regs;
    wr(12'h100, 32'h0000_00F0);
    chk_rd("R3 mask clear", 12'h080, 32'hFFFF_FF0F);
    wr(12'h100, 32'h0);
    chk_rd("R3 zero bits no effect", 12'h080, 32'hFFFF_FF0F);
    wr(12'h0C0, 32'h0000_0010);
    chk_rd("R3 mask set", 12'h080, 32'hFFFF_FF1F);
    wr(12'h184, 32'h3);
    chk_rd("R4 sens set w1", 12'h144, 32'h3);
    chk_rd("R2 sens word0 untouched", 12'h140, 32'h0);
    wr(12'h1C4, 32'h1);
    chk_rd("R4 sens clear", 12'h144, 32'h2);
    wr(12'h1C4, 32'hFFFF_FFFF);
    wr(12'h340, 32'h0000_0300);
    wr(12'h380, 32'h0000_0100);
    chk_rd("R5 pol set/clear", 12'h300, 32'h0000_0200);
    wr(12'h380, 32'hFFFF_FFFF);
    chk_rd("R11 same-cycle read", 12'h300, 32'h0);
    wr(12'h400, 32'hFFFF_FFFF);
    wr(12'h404, 32'hFFFF_FFFF);
    chk_rd("R9 dom readback", 12'h404, 32'hFFFF_FFFF);
  endtask

  task automatic t_edge;
    pin_i[5] = 0;
    tick(2);
    chk_rd("R6 not yet after two edges", 12'h000, 32'h0);
    tick();
    chk_rd("R6 falling latched", 12'h000, 32'h20);
    chk("R10 irq unmasked", {31'b0, irq_o}, 32'h1);
    pin_i[5] = 1;
    tick(4);
    chk_rd("R6 holds after pin return", 12'h000, 32'h20);
    wr(12'h040, 32'h1);
    chk_rd("R7 other ack bit no effect", 12'h000, 32'h20);
    wr(12'h040, 32'h20);
    chk_rd("R7 ack clears", 12'h000, 32'h0);
    chk("R10 irq drops", {31'b0, irq_o}, 32'h0);
    wr(12'h344, 32'h100);
    pin_i[40] = 0;
    tick(4);
    chk_rd("R6 unselected edge ignored", 12'h004, 32'h0);
    pin_i[40] = 1;
    tick(3);
    chk_rd("R6 rising ch40 word1 bit8", 12'h004, 32'h100);
    chk("R10 masked no irq", {31'b0, irq_o}, 32'h0);
    wr(12'h104, 32'h100);
    chk("R10 unmask raises irq", {31'b0, irq_o}, 32'h1);
    wr(12'h044, 32'h100);
    chk("R10 irq after ack", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_ack_race;
    pin_i[5] = 0;
    tick(2);
    wr(12'h040, 32'h20);
    chk_rd("R7 edge wins over ack", 12'h000, 32'h20);
    pin_i[5] = 1;
    tick(4);
    wr(12'h040, 32'h20);
    chk_rd("R7 cleared after race", 12'h000, 32'h0);
  endtask

  task automatic t_level;
    wr(12'h180, 32'h80);
    tick();
    chk_rd("R8 inactive level", 12'h000, 32'h0);
    pin_i[7] = 0;
    tick(3);
    chk_rd("R8 level asserted", 12'h000, 32'h80);
    chk("R10 level irq", {31'b0, irq_o}, 32'h1);
    wr(12'h040, 32'h80);
    chk_rd("R8 ack clears one cycle", 12'h000, 32'h0);
    tick();
    chk_rd("R8 re-asserted", 12'h000, 32'h80);
    pin_i[7] = 1;
    tick(2);
    chk_rd("R8 still set in sync delay", 12'h000, 32'h80);
    tick();
    chk_rd("R8 follows level low", 12'h000, 32'h0);
  endtask

  task automatic t_domain;
    wr(12'h400, 32'hFFFF_FF5F);
    chk_rd("R9 dom word write", 12'h400, 32'hFFFF_FF5F);
    pin_i[5] = 0;
    pin_i[7] = 0;
    tick(4);
    chk_rd("R9 unrouted channels silent", 12'h000, 32'h0);
    chk("R9 no irq", {31'b0, irq_o}, 32'h0);
    pin_i[5] = 1;
    pin_i[7] = 1;
    tick(4);
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick();
    t_reset();
    t_regs();
    t_edge();
    t_ack_race();
    t_level();
    t_domain();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule